// File: doc/BRIEF.md
# External Bus Hold Arbiter

This block lets another master take over the external memory bus and then gives the bus back to the local bus cycle engine. The other master pulls an active-low hold request pin low. The arbiter waits until the bus cycle in progress has finished. It then floats the address, data and strobe outputs and answers with an active-low acknowledge.

While the bus is away, the local engine can show through a "need bus" input that it has work queued. The arbiter then pulls an active-low bus-request output low to ask the other master to let go. The bus comes back only when the other master removes its hold request. After that the arbiter stops acknowledging, drives the bus again one cycle later, and lets the engine start new cycles.

The hold request pin is asynchronous and passes through a synchronizer before the arbiter uses it. The engine reports a running cycle on `cycle_busy`. It may start a new cycle only while `cycle_ok` is high.

Top module: `ext_hold_arb`

## Requirements
- R1: After reset, `hold_ack_n` = 1, `bus_want_n` = 1, `bus_drive` = 1 and `cycle_ok` = 1.
- R2: `hold_req_n` passes through a two-stage synchronizer. A low level held from just after an edge makes `cycle_ok` fall after the third rising edge. While the bus is still owned, `cycle_ok` = 0 means a release is pending, and the engine must not start a new cycle.
- R3: While `cycle_busy` = 1, `bus_drive` stays 1 and `hold_ack_n` stays 1. The bus is released only at a cycle boundary.
- R4: In a pending release, `bus_drive` falls at the first edge that sees `cycle_busy` = 0. `hold_ack_n` falls one edge later, so the outputs float one cycle before the acknowledge.
- R5: `bus_want_n` goes low only at an edge where `hold_ack_n` was already 0 and `need_bus` = 1. It then stays low until the bus is regained.
- R6: While the bus is released and the hold request is still low, `bus_want_n` = 0 does not regain the bus: `hold_ack_n` stays 0 and `bus_drive` stays 0.
- R7: After `hold_req_n` rises, `hold_ack_n` rises after the third edge. `bus_drive` and `cycle_ok` return to 1, and `bus_want_n` returns to 1, one edge later.
- R8: If the hold request is withdrawn when `bus_want_n` was never asserted, the bus is regained with the same timing as R7, and `bus_want_n` stays 1 throughout.
- R9: If the hold request is withdrawn while the arbiter still waits for a cycle to end, the arbiter returns to owning the bus without floating it or acknowledging. `cycle_ok` rises after the third edge following the rise of `hold_req_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_req_n | input | 1 | Asynchronous hold request from the other master, active low |
| cycle_busy | input | 1 | High while the local engine runs a bus cycle |
| need_bus | input | 1 | High while the local engine has cycles waiting |
| hold_ack_n | output | 1 | Hold acknowledge, active low |
| bus_want_n | output | 1 | Request to get the bus back, active low |
| bus_drive | output | 1 | High while address, data and strobe outputs are driven; low floats them |
| cycle_ok | output | 1 | High while the engine may start a new bus cycle |

## Verification
The hardest situation to reach is a hold request that is withdrawn while the arbiter is still waiting for a long cycle to end (R9). The bus must come back without the outputs ever floating. The bench holds `cycle_busy` high and toggles the pin inside that window with directed timing. A second directed case has `need_bus` high before the acknowledge appears, to show that the bus request waits for the acknowledge. A constrained-random phase then models an engine that starts cycles only when permitted. It checks the float, acknowledge and request ordering on every cycle.

// File: rtl/ext_hold_arb_pkg.sv
package ext_hold_arb_pkg;

    typedef enum logic [1:0] {
        ST_OWNED    = 2'd0,
        ST_WAIT_END = 2'd1,
        ST_RELEASED = 2'd2,
        ST_REGAIN   = 2'd3
    } arb_state_t;

    typedef struct packed {
        logic ack;
        logic want;
    } arb_flags_t;

    function automatic logic bus_floating(arb_state_t s);
        return (s == ST_RELEASED) || (s == ST_REGAIN);
    endfunction

endpackage

// File: rtl/hold_sync.sv
module hold_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic req
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], pin_n};
    end

    assign req = ~chain[STAGES-1];
endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
    import ext_hold_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hold_req,
    input  logic       cycle_busy,
    input  logic       need_bus,
    output arb_state_t state,
    output arb_flags_t flags
);
    arb_state_t nxt;
    arb_flags_t flags_nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OWNED:    if (hold_req) nxt = ST_WAIT_END;
            ST_WAIT_END: if (!hold_req) nxt = ST_OWNED;
                         else if (!cycle_busy) nxt = ST_RELEASED;
            ST_RELEASED: if (!hold_req) nxt = ST_REGAIN;
            ST_REGAIN:   nxt = ST_OWNED;
            default:     nxt = ST_OWNED;
        endcase
    end

    always_comb begin
        flags_nxt.ack = (state == ST_RELEASED) && hold_req;
        if (nxt == ST_OWNED)
            flags_nxt.want = 1'b0;
        else if (state == ST_RELEASED && flags.ack && need_bus)
            flags_nxt.want = 1'b1;
        else
            flags_nxt.want = flags.want;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_OWNED;
            flags <= '0;
        end else begin
            state <= nxt;
            flags <= flags_nxt;
        end
    end

    // R3: the bus only leaves the waiting state at a cycle boundary
    a_r3_boundary_release: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RELEASED && $past(state) == ST_WAIT_END) |-> !$past(cycle_busy));

    // R5: the want flag rises only after acknowledge was already given
    a_r5_want_after_ack: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.want) |-> $past(flags.ack));

    // R6: bus is not regained while the hold request persists
    a_r6_no_early_regain: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_RELEASED && $past(hold_req)) |-> state == ST_RELEASED);
endmodule

// File: rtl/ext_hold_arb.sv
module ext_hold_arb
    import ext_hold_arb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic hold_req_n,
    input  logic cycle_busy,
    input  logic need_bus,
    output logic hold_ack_n,
    output logic bus_want_n,
    output logic bus_drive,
    output logic cycle_ok
);
    logic       hold_req;
    arb_state_t state;
    arb_flags_t flags;

    hold_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .pin_n (hold_req_n),
        .req   (hold_req)
    );

    hold_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .hold_req   (hold_req),
        .cycle_busy (cycle_busy),
        .need_bus   (need_bus),
        .state      (state),
        .flags      (flags)
    );

    assign hold_ack_n = ~flags.ack;
    assign bus_want_n = ~flags.want;
    assign bus_drive  = ~bus_floating(state);
    assign cycle_ok   = (state == ST_OWNED);

    // R4: acknowledge never coexists with driven outputs
    a_r4_ack_floats: assert property (@(posedge clk) disable iff (rst)
        !hold_ack_n |-> !bus_drive);

    // R4: outputs float one cycle before acknowledge asserts
    a_r4_float_first: assert property (@(posedge clk) disable iff (rst)
        $fell(hold_ack_n) |-> !$past(bus_drive));

    // R7: outputs driven again one cycle after acknowledge is withdrawn
    a_r7_drive_after_ack: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_drive) |-> $past(hold_ack_n) && $past(!bus_drive));

    // R5: request for the bus only while the bus is away
    a_r5_want_floating: assert property (@(posedge clk) disable iff (rst)
        !bus_want_n |-> !bus_drive);
endmodule

// File: tb/tb_ext_hold_arb.sv
module tb_ext_hold_arb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hold_req_n = 1'b1;
    logic cycle_busy = 1'b0;
    logic need_bus = 1'b0;
    logic hold_ack_n, bus_want_n, bus_drive, cycle_ok;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    ext_hold_arb dut (
        .clk(clk), .rst(rst), .hold_req_n(hold_req_n), .cycle_busy(cycle_busy),
        .need_bus(need_bus), .hold_ack_n(hold_ack_n), .bus_want_n(bus_want_n),
        .bus_drive(bus_drive), .cycle_ok(cycle_ok)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [3:0] pack_out(logic a, logic w, logic d, logic o);
        return {a, w, d, o};
    endfunction

    task automatic chk(string req, logic [3:0] exp);
        logic [3:0] act;
        act = pack_out(hold_ack_n, bus_want_n, bus_drive, cycle_ok);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {ack_n,want_n,drive,ok} actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_up();
        end
    end

    // Outputs {ack_n, want_n, drive, ok}
    localparam logic [3:0] OWNED_O = 4'b1111;
    localparam logic [3:0] WAIT_O  = 4'b1110;
    localparam logic [3:0] FLOAT_O = 4'b1100;
    localparam logic [3:0] ACK_O   = 4'b0100;
    localparam logic [3:0] WANT_O  = 4'b0000;
    localparam logic [3:0] RGN_O   = 4'b1000;

    initial begin
        logic p_drive, p_ack, p_busy;
        step(3);
        rst = 1'b0;
        step(1);
        chk("R1 reset", OWNED_O);

        // idle release, bus request, regain
        hold_req_n = 1'b0;
        step(2); chk("R2 sync delay", OWNED_O);
        step(1); chk("R2 pending", WAIT_O);
        step(1); chk("R4 float first", FLOAT_O);
        step(1); chk("R4 ack", ACK_O);
        need_bus = 1'b1;
        step(1); chk("R5 want", WANT_O);
        step(6); chk("R6 no regain while held", WANT_O);
        hold_req_n = 1'b1;
        step(2); chk("R7 sync", WANT_O);
        step(1); chk("R7 ack off", RGN_O);
        step(1); chk("R7 drive back", OWNED_O);
        need_bus = 1'b0;

        // running cycle, release without want
        cycle_busy = 1'b1;
        hold_req_n = 1'b0;
        step(3); chk("R3 waiting", WAIT_O);
        step(5); chk("R3 busy holds bus", WAIT_O);
        cycle_busy = 1'b0;
        step(1); chk("R4 float at boundary", FLOAT_O);
        step(1); chk("R4 ack", ACK_O);
        step(4); chk("R8 no want", ACK_O);
        hold_req_n = 1'b1;
        step(3); chk("R8 ack off", 4'b1100);
        step(1); chk("R8 regained", OWNED_O);

        // withdraw during wait
        cycle_busy = 1'b1;
        hold_req_n = 1'b0;
        step(3); chk("R9 waiting", WAIT_O);
        hold_req_n = 1'b1;
        step(2); chk("R9 still waiting", WAIT_O);
        step(1); chk("R9 back owned", OWNED_O);
        cycle_busy = 1'b0;
        step(3); chk("R9 stays owned", OWNED_O);

        // need before acknowledge
        need_bus = 1'b1;
        hold_req_n = 1'b0;
        step(4); chk("R5 float, no want yet", FLOAT_O);
        step(1); chk("R5 ack, no want yet", ACK_O);
        step(1); chk("R5 want after ack", WANT_O);
        hold_req_n = 1'b1;
        need_bus = 1'b0;
        step(4); chk("R7 regain", OWNED_O);

        // constrained random with ordering checks
        void'($urandom(32'd1234));
        p_drive = bus_drive; p_ack = hold_ack_n; p_busy = cycle_busy;
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 16) == 0) hold_req_n = ~hold_req_n;
            need_bus = ($urandom % 4) != 0;
            if (cycle_busy) cycle_busy = ($urandom % 3) != 0;
            else if (cycle_ok) cycle_busy = ($urandom % 2) == 0;
            p_busy = cycle_busy;
            p_drive = bus_drive; p_ack = hold_ack_n;
            step(1);
            checks++;
            if (!hold_ack_n && bus_drive) begin
                errors++;
                $display("FAIL R4 random: drive=%b expected=0 with ack", bus_drive);
            end
            checks++;
            if (p_drive && !bus_drive && p_busy) begin
                errors++;
                $display("FAIL R3 random: busy_prev=%b expected=0 at release", p_busy);
            end
            checks++;
            if (!bus_want_n && bus_drive) begin
                errors++;
                $display("FAIL R5 random: drive=%b expected=0 with want", bus_drive);
            end
            checks++;
            if (!p_drive && bus_drive && !p_ack) begin
                errors++;
                $display("FAIL R7 random: ack_prev=%b expected=1 at redrive", p_ack);
            end
        end
        done = 1'b1;
        finish_up();
    end
endmodule